// File: doc/BRIEF.md
# Hardware Page Table Walker

This block turns one virtual address into a physical address by walking hierarchical paging structures in memory. The walk follows one of three table formats, chosen from the control state captured when the request is accepted. The first is a two-level format with 4-byte entries and optional 4 MB large pages. The second is a three-level extended format with 8-byte entries, where a directory-level large page maps 2 MB. The third is a four-level format with 8-byte entries, which adds 1 GB pages at the third level. When translation is switched off, the virtual address passes straight through.

Table entries are fetched through a simple read port. The walker asserts a one-cycle read strobe with a 32-bit-aligned address. Some later cycle, the memory returns one 32-bit data word with a valid strobe. An 8-byte entry takes two such reads, low word first. An address-line mask is ANDed into every address driven on the port. A walk that meets an entry whose present bit is clear stops and reports a fault.

Only one translation is in flight at a time. The block raises `busy` while it works and ends each request with a single-cycle `done` pulse. The result or the fault is held on the response outputs until the next request.

Top module: `xw_walker`

## Requirements
- R1: With `pg_on` low, a request completes with `done` in the cycle right after the request cycle. It returns `rsp_pa` equal to `req_va` zero-extended, `rsp_size` = 0 and `rsp_fault` = 0, and it issues no memory read.
- R2: With `pae_on` low, the walk uses 4-byte entries and a single read per entry. The directory base is `root_ptr[31:12]`×4096. The directory index is VA[31:22] and the table index is VA[21:12]. A present table entry gives `rsp_pa` = {entry[31:12], VA[11:0]} and `rsp_size` = 0 (4 KB).
- R3: With `pae_on` low and `pse_on` high, a present directory entry with bit 7 set is a 4 MB leaf. It gives PA[39:32] = entry[20:13], PA[31:22] = entry[31:22], PA[21:0] = VA[21:0] and `rsp_size` = 2.
- R4: With `pae_on` low and `pse_on` low, bit 7 of a directory entry is ignored, and the entry points to a table at entry[31:12]×4096.
- R5: With `pae_on` high and `long_on` low, the top table sits at `root_ptr[31:5]`×32 and has 4 entries of 8 bytes, selected by VA[31:30]. Bit 7 of a top entry is ignored. The directory uses VA[29:21] and the table uses VA[20:12], with 8-byte entries.
- R6: In both 8-byte formats, a present directory entry with bit 7 set is a 2 MB leaf. It gives PA = {entry[51:21], VA[20:0]} and `rsp_size` = 1. A table entry gives PA = {entry[51:12], VA[11:0]} and `rsp_size` = 0.
- R7: With `pae_on` and `long_on` both high, the top table sits at `root_ptr[51:12]`×4096 and is indexed by VA[47:39]. The next level is indexed by VA[38:30]. A present entry there with bit 7 set is a 1 GB leaf: PA = {entry[51:30], VA[29:0]} and `rsp_size` = 3.
- R8: Entry bits 63:52 are ignored, including the no-execute bit 63, both in table bases and in leaf frames. Next-table bases are taken from bits 51:12.
- R9: Every address driven on `mem_addr` has been ANDed with the `a20_mask` captured at request time.
- R10: An entry with bit 0 clear at any level ends the walk with `rsp_fault` = 1, `rsp_pa` = 0 and `rsp_size` = 0. No further read is issued.
- R11: An 8-byte entry at address A is read as two beats, first at A and then at A+4, each masked. A 4-byte entry takes one beat. The exact read sequence of a walk is fixed by R2 to R9.
- R12: After reset, `busy`, `done` and `mem_rd` are low. `busy` rises only on an accepted request. `done` lasts one cycle, after which `busy` is low. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_on | input | 1 | Translation enable |
| pae_on | input | 1 | Selects the 8-byte entry formats |
| pse_on | input | 1 | Allows 4 MB pages in the two-level format |
| long_on | input | 1 | Selects four-level walking when `pae_on` is high |
| root_ptr | input | 64 | Top-level table pointer |
| a20_mask | input | PA_W | Mask ANDed into every table address |
| req_valid | input | 1 | Translation request strobe, taken when idle |
| req_va | input | VA_W | Virtual address to translate |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_size | output | 2 | Page size: 0=4 KB, 1=2 MB, 2=4 MB, 3=1 GB |
| rsp_fault | output | 1 | Not-present fault |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_addr | output | PA_W | Read address of one 32-bit word |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 32 | Read data word |

## Verification
Table images are built in bench memory for each format. The bench then sweeps the virtual address across combinations of every index field: present leaves, missing entries at each level, large-page leaves and table pointers. This separates index selection per level, leaf-versus-pointer decisions and offset merging. Two sweeps reuse the same tables with `pse_on` cleared and with a root pointer that only resolves through the address mask. These tell apart a correct large-page enable and mask path from one that is ignored. Entries with bit 7 set at the extended-format top level and entries with high bits set check that those bits are ignored. Every walk's full read-address sequence is compared with one computed arithmetically in the bench, alongside the physical address, the size and the fault.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int ENT_W  = 64;
    localparam int BEAT_W = 32;

    typedef enum logic [1:0] {
        MODE_TWO  = 2'd0,
        MODE_PAE  = 2'd1,
        MODE_FOUR = 2'd2
    } walk_mode_e;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_4M = 2'd2,
        PG_1G = 2'd3
    } page_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_state_e;
endpackage

// File: rtl/xw_index.sv
module xw_index
    import xw_pkg::*;
#(
    parameter int VA_W = 48,
    parameter int PA_W = 52
) (
    input  walk_mode_e        mode,
    input  logic [1:0]        lvl,
    input  logic [VA_W-1:0]   va,
    input  logic [PA_W-1:0]   base,
    input  logic [PA_W-1:0]   a20,
    output logic [PA_W-1:0]   ent_addr
);
    localparam int LVLS    = 4;
    localparam int FLD9_W  = 9;
    localparam int FLD10_W = 10;

    logic [FLD9_W-1:0]  fld9 [LVLS];
    logic [FLD10_W-1:0] fld10;
    logic [FLD9_W-1:0]  sel9;
    logic [PA_W-1:0]    offs;

    for (genvar g = 0; g < LVLS; g++) begin : g_fld
        assign fld9[g] = va[12 + FLD9_W*g +: FLD9_W];
    end

    always_comb begin
        fld10 = lvl[0] ? va[31:22] : va[21:12];
        if (mode == MODE_PAE && lvl == 2'd2) begin
            sel9 = {7'b0, va[31:30]};
        end else begin
            sel9 = fld9[lvl];
        end
        if (mode == MODE_TWO) begin
            offs = PA_W'({fld10, 2'b00});
        end else begin
            offs = PA_W'({sel9, 3'b000});
        end
        ent_addr = (base + offs) & a20;
    end

    logic unused_va;
    assign unused_va = ^{va[11:0], va[VA_W-1:48]};
endmodule

// File: rtl/xw_decode.sv
module xw_decode
    import xw_pkg::*;
#(
    parameter int VA_W = 48,
    parameter int PA_W = 52
) (
    input  walk_mode_e         mode,
    input  logic [1:0]         lvl,
    input  logic               pse,
    input  logic [ENT_W-1:0]   entry,
    input  logic [VA_W-1:0]    va,
    output logic               present,
    output logic               leaf,
    output page_size_e         leaf_sz,
    output logic [PA_W-1:0]    leaf_pa,
    output logic [PA_W-1:0]    next_base
);
    localparam int PS_BIT = 7;

    logic [PA_W-1:0] ent_pa;
    logic            ps;

    always_comb begin
        ent_pa  = entry[PA_W-1:0];
        ps      = entry[PS_BIT];
        present = entry[0];
        leaf    = 1'b0;
        leaf_sz = PG_4K;
        leaf_pa = '0;
        if (mode == MODE_TWO) begin
            next_base = PA_W'({entry[31:12], 12'b0});
            if (lvl == 2'd0) begin
                leaf    = 1'b1;
                leaf_pa = PA_W'({entry[31:12], va[11:0]});
            end else if (ps && pse) begin
                leaf    = 1'b1;
                leaf_sz = PG_4M;
                leaf_pa = PA_W'({entry[20:13], entry[31:22], va[21:0]});
            end
        end else begin
            next_base = {ent_pa[PA_W-1:12], 12'b0};
            if (lvl == 2'd0) begin
                leaf    = 1'b1;
                leaf_pa = {ent_pa[PA_W-1:12], va[11:0]};
            end else if (lvl == 2'd1 && ps) begin
                leaf    = 1'b1;
                leaf_sz = PG_2M;
                leaf_pa = {ent_pa[PA_W-1:21], va[20:0]};
            end else if (lvl == 2'd2 && ps && mode == MODE_FOUR) begin
                leaf    = 1'b1;
                leaf_sz = PG_1G;
                leaf_pa = {ent_pa[PA_W-1:30], va[29:0]};
            end
        end
    end

    logic unused_bits;
    assign unused_bits = ^{entry[ENT_W-1:PA_W], entry[6:1], entry[11:8], va[VA_W-1:30]};
endmodule

// File: rtl/xw_walker.sv
module xw_walker
    import xw_pkg::*;
#(
    parameter int VA_W = 48,
    parameter int PA_W = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_on,
    input  logic              pae_on,
    input  logic              pse_on,
    input  logic              long_on,
    input  logic [63:0]       root_ptr,
    input  logic [PA_W-1:0]   a20_mask,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    output logic              busy,
    output logic              done,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [1:0]        rsp_size,
    output logic              rsp_fault,
    output logic              mem_rd,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_valid,
    input  logic [BEAT_W-1:0] mem_data
);
    localparam int HI_OFS = BEAT_W / 8;

    typedef struct packed {
        walk_state_e       st;
        walk_mode_e        mode;
        logic [1:0]        lvl;
        logic              hi;
        logic              pse;
        logic [PA_W-1:0]   base;
        logic [PA_W-1:0]   a20;
        logic [VA_W-1:0]   va;
        logic [BEAT_W-1:0] lo;
        logic [PA_W-1:0]   pa;
        page_size_e        sz;
        logic              fault;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [PA_W-1:0]  ent_addr;
    logic [ENT_W-1:0] entry;
    logic             ent_present, ent_leaf;
    page_size_e       leaf_sz;
    logic [PA_W-1:0]  leaf_pa, next_base;

    xw_index #(.VA_W(VA_W), .PA_W(PA_W)) u_index (
        .mode     (r_q.mode),
        .lvl      (r_q.lvl),
        .va       (r_q.va),
        .base     (r_q.base),
        .a20      (r_q.a20),
        .ent_addr (ent_addr)
    );

    assign entry = (r_q.mode == MODE_TWO) ? {32'b0, mem_data} : {mem_data, r_q.lo};

    xw_decode #(.VA_W(VA_W), .PA_W(PA_W)) u_decode (
        .mode      (r_q.mode),
        .lvl       (r_q.lvl),
        .pse       (r_q.pse),
        .entry     (entry),
        .va        (r_q.va),
        .present   (ent_present),
        .leaf      (ent_leaf),
        .leaf_sz   (leaf_sz),
        .leaf_pa   (leaf_pa),
        .next_base (next_base)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va    = req_va;
                    r_d.a20   = a20_mask;
                    r_d.pse   = pse_on;
                    r_d.hi    = 1'b0;
                    r_d.fault = 1'b0;
                    r_d.pa    = '0;
                    r_d.sz    = PG_4K;
                    r_d.mode  = MODE_TWO;
                    r_d.st    = ST_ISSUE;
                    if (!pg_on) begin
                        r_d.pa = PA_W'(req_va);
                        r_d.st = ST_RESP;
                    end else if (!pae_on) begin
                        r_d.lvl  = 2'd1;
                        r_d.base = PA_W'({root_ptr[31:12], 12'b0}) & a20_mask;
                    end else if (long_on) begin
                        r_d.mode = MODE_FOUR;
                        r_d.lvl  = 2'd3;
                        r_d.base = PA_W'({root_ptr[PA_W-1:12], 12'b0}) & a20_mask;
                    end else begin
                        r_d.mode = MODE_PAE;
                        r_d.lvl  = 2'd2;
                        r_d.base = PA_W'({root_ptr[31:5], 5'b0}) & a20_mask;
                    end
                end
            end
            ST_ISSUE: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_valid) begin
                    if (r_q.mode != MODE_TWO && !r_q.hi) begin
                        r_d.lo = mem_data;
                        r_d.hi = 1'b1;
                        r_d.st = ST_ISSUE;
                    end else begin
                        r_d.hi = 1'b0;
                        if (!ent_present) begin
                            r_d.fault = 1'b1;
                            r_d.st    = ST_RESP;
                        end else if (ent_leaf) begin
                            r_d.pa = leaf_pa;
                            r_d.sz = leaf_sz;
                            r_d.st = ST_RESP;
                        end else begin
                            r_d.base = next_base & r_q.a20;
                            r_d.lvl  = r_q.lvl - 2'd1;
                            r_d.st   = ST_ISSUE;
                        end
                    end
                end
            end
            ST_RESP: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = (r_q.st == ST_RESP);
    assign rsp_pa    = r_q.pa;
    assign rsp_size  = r_q.sz;
    assign rsp_fault = r_q.fault;
    assign mem_rd    = (r_q.st == ST_ISSUE);
    assign mem_addr  = r_q.hi ? ((ent_addr + PA_W'(HI_OFS)) & r_q.a20) : ent_addr;

    logic unused_root;
    assign unused_root = ^{root_ptr[63:PA_W], root_ptr[4:0]};

    // R12: one-cycle completion, then idle
    a_r12_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R12: work starts only from an accepted request
    a_r12_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    // R9: every port address respects the captured mask
    a_r9_addr_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ((mem_addr & ~r_q.a20) == '0));
    // R11: word-aligned beats, second beats only in 8-byte formats
    a_r11_beat_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr[1:0] == 2'b00) && (!r_q.hi || r_q.mode != MODE_TWO));
    // R3: two-level walks end in 4 KB or 4 MB pages only
    a_r3_two_level_sizes: assert property (@(posedge clk) disable iff (!rst_n)
        done && !rsp_fault && r_q.mode == MODE_TWO |-> rsp_size inside {PG_4K, PG_4M});
    // R6: 8-byte formats never produce a 4 MB page
    a_r6_wide_sizes: assert property (@(posedge clk) disable iff (!rst_n)
        done && r_q.mode != MODE_TWO |-> rsp_size != PG_4M);
    // R10: a fault response carries a cleared address
    a_r10_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_fault) |-> done && rsp_pa == '0);
endmodule

// File: tb/sim_xw_walker.sv
module sim_xw_walker;
    localparam int CLK_P = 10;
    localparam int VA_W  = 48;
    localparam int PA_W  = 52;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg_on = 1'b0, pae_on = 1'b0, pse_on = 1'b0, long_on = 1'b0;
    logic [63:0] root_ptr = '0;
    logic [PA_W-1:0] a20_mask = '1;
    logic req_valid = 1'b0;
    logic [VA_W-1:0] req_va = '0;
    logic busy, done, rsp_fault, mem_rd;
    logic [PA_W-1:0] rsp_pa, mem_addr;
    logic [1:0] rsp_size;
    logic mem_valid = 1'b0;
    logic [31:0] mem_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    int last_cyc = 0;

    logic [31:0] mem_img [logic [51:0]];
    logic [51:0] got_q[$];
    logic [51:0] exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    xw_walker #(.VA_W(VA_W), .PA_W(PA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pg_on(pg_on), .pae_on(pae_on), .pse_on(pse_on),
        .long_on(long_on), .root_ptr(root_ptr), .a20_mask(a20_mask),
        .req_valid(req_valid), .req_va(req_va), .busy(busy), .done(done),
        .rsp_pa(rsp_pa), .rsp_size(rsp_size), .rsp_fault(rsp_fault),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data)
    );

    function automatic logic [31:0] rd32(input logic [51:0] a);
        return mem_img.exists(a) ? mem_img[a] : 32'h0;
    endfunction

    task automatic wr32(input logic [51:0] a, input logic [31:0] d);
        mem_img[a] = d;
    endtask

    task automatic wr64(input logic [51:0] a, input logic [63:0] d);
        mem_img[a] = d[31:0];
        mem_img[a + 52'd4] = d[63:32];
    endtask

    always @(posedge clk) begin
        mem_valid <= mem_rd;
        mem_data  <= rd32(mem_addr);
    end

    always @(negedge clk) begin
        if (mem_rd) got_q.push_back(mem_addr);
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void ref_walk(input logic [47:0] va, output logic [51:0] pa,
                                     output logic [1:0] sz, output logic flt);
        logic [51:0] base, a, a_hi;
        logic [31:0] e32;
        logic [63:0] e;
        logic [51:0] idx;
        int lvl;
        exp_q.delete();
        pa = '0; sz = 2'd0; flt = 1'b0;
        if (!pg_on) begin
            pa = 52'(va);
            return;
        end
        if (!pae_on) begin
            base = {20'b0, root_ptr[31:12], 12'b0};
            a = (base + 52'(va[31:22]) * 4) & a20_mask;
            exp_q.push_back(a);
            e32 = rd32(a);
            if (!e32[0]) begin flt = 1'b1; return; end
            if (e32[7] && pse_on) begin
                pa = {12'b0, e32[20:13], e32[31:22], va[21:0]};
                sz = 2'd2;
                return;
            end
            base = {20'b0, e32[31:12], 12'b0};
            a = (base + 52'(va[21:12]) * 4) & a20_mask;
            exp_q.push_back(a);
            e32 = rd32(a);
            if (!e32[0]) begin flt = 1'b1; return; end
            pa = {20'b0, e32[31:12], va[11:0]};
            return;
        end
        lvl  = long_on ? 3 : 2;
        base = long_on ? {root_ptr[51:12], 12'b0} : {20'b0, root_ptr[31:5], 5'b0};
        base = base & a20_mask;
        while (1) begin
            if (lvl == 2 && !long_on) idx = 52'(va[31:30]);
            else idx = 52'((va >> (12 + 9*lvl)) & 48'h1ff);
            a    = (base + idx * 8) & a20_mask;
            a_hi = (a + 52'd4) & a20_mask;
            exp_q.push_back(a);
            exp_q.push_back(a_hi);
            e = {rd32(a_hi), rd32(a)};
            if (!e[0]) begin flt = 1'b1; return; end
            if (lvl == 0) begin
                pa = {e[51:12], va[11:0]};
                return;
            end
            if (lvl == 1 && e[7]) begin
                pa = {e[51:21], va[20:0]}; sz = 2'd1;
                return;
            end
            if (lvl == 2 && long_on && e[7]) begin
                pa = {e[51:30], va[29:0]}; sz = 2'd3;
                return;
            end
            base = {e[51:12], 12'b0} & a20_mask;
            lvl--;
        end
    endfunction

    task automatic xlate(input string tag, input logic [47:0] va, input bit poke);
        logic [51:0] epa;
        logic [1:0]  esz;
        logic        eflt;
        int cyc;
        bit same;
        ref_walk(va, epa, esz, eflt);
        @(negedge clk);
        got_q.delete();
        req_valid = 1'b1;
        req_va    = va;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 4000) begin
            if (poke && cyc == 2) begin
                req_valid = 1'b1;
                req_va    = 48'h0000_4000_0000;
            end
            @(negedge clk);
            req_valid = 1'b0;
            req_va    = va;
            cyc++;
        end
        last_cyc = cyc;
        chk({tag, " done seen"}, 64'(done), 64'd1);
        chk({tag, " pa"}, 64'(rsp_pa), 64'(epa));
        chk({tag, " size"}, 64'(rsp_size), 64'(esz));
        chk({tag, " fault R10"}, 64'(rsp_fault), 64'(eflt));
        same = (got_q.size() == exp_q.size());
        for (int i = 0; i < got_q.size() && same; i++) begin
            if (got_q[i] !== exp_q[i]) same = 1'b0;
        end
        n_chk++;
        if (!same) begin
            n_fail++;
            $display("FAIL %s R9 R11 read sequence actual_len=%0d expected_len=%0d actual_first=%h expected_first=%h",
                     tag, got_q.size(), exp_q.size(),
                     (got_q.size() > 0) ? got_q[0] : 52'h0, (exp_q.size() > 0) ? exp_q[0] : 52'h0);
        end
        @(negedge clk);
        chk({tag, " R12 pulse ends"}, 64'({done, busy}), 64'd0);
    endtask

    initial begin
        #(CLK_P * 190000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int dones;
        logic [47:0] va;
        // Two-level tables: directory at 0x1000
        wr32(52'h1000, 32'h0000_2001);
        wr32(52'h1004, 32'h0C0B_4081);
        wr32(52'h1008, 32'h0080_0081);
        for (int j = 0; j < 16; j++) begin
            if (j != 5) wr32(52'h2000 + 52'(j*4), 32'h0010_0001 + 32'(j) * 32'h1000);
            wr32(52'h80_0000 + 52'(j*4), 32'h0033_3001 + 32'(j) * 32'h1000);
        end
        // Extended three-level tables: top at 0x3020
        wr64(52'h3020, 64'h0000_0000_0000_4081);
        wr64(52'h3030, 64'h8000_0000_0000_5001);
        wr64(52'h3038, 64'hFFF0_0000_0000_4001);
        wr64(52'h4000, 64'h0000_0000_0000_6001);
        wr64(52'h4008, 64'h8000_0012_3400_0081);
        wr64(52'h4018, 64'h0000_0000_0000_6003);
        wr64(52'h5000, 64'h0000_0000_0000_7001);
        for (int j = 0; j < 10; j++) begin
            if (j != 4) wr64(52'h6000 + 52'(j*8), 64'h0000_00AB_0000_0001 + 64'(j) * 64'h1000);
            wr64(52'h7000 + 52'(j*8), 64'h8000_0001_2300_0001 + 64'(j) * 64'h1000);
        end
        // Four-level tables: top at 0x8000
        wr64(52'h8000, 64'h0000_0000_0000_9001);
        wr64(52'h8008, 64'h0000_0000_0000_A001);
        wr64(52'h9000, 64'h0000_0000_0000_4001);
        wr64(52'h9008, 64'h0000_0007_C000_0081);
        wr64(52'hA000, 64'h8000_0000_4000_0081);
        wr64(52'hA008, 64'hFFF0_0000_0000_5001);

        repeat (4) @(negedge clk);
        chk("R12 reset busy", 64'(busy), 64'd0);
        chk("R12 reset done", 64'(done), 64'd0);
        chk("R12 reset mem_rd", 64'(mem_rd), 64'd0);
        rst_n = 1'b1;

        // R1: translation off
        pg_on = 1'b0; pae_on = 1'b1; long_on = 1'b1;
        foreach (got_q[i]) got_q[i] = '0;
        for (int k = 0; k < 6; k++) begin
            xlate("R1 passthrough", 48'h1234_5678_9ABC ^ (48'(k) << (k * 7)), 1'b0);
            chk("R1 done next cycle", 64'(last_cyc), 64'd0);
        end

        // R2 R3: two-level with large pages enabled
        pg_on = 1'b1; pae_on = 1'b0; long_on = 1'b0; pse_on = 1'b1;
        root_ptr = 64'hFFFF_FFFF_0000_1ABC;
        for (int d = 0; d < 4; d++)
            for (int j = 0; j < 18; j++)
                xlate("R2 R3 two-level sweep", (48'(d) << 22) | (48'(j) << 12) | 48'((d*37 + j*11) & 12'hfff), 1'b0);
        xlate("R3 literal", 48'h0040_1234, 1'b0);
        chk("R3 literal pa", 64'(rsp_pa), 64'h5A_0C00_1234);
        chk("R3 literal size", 64'(rsp_size), 64'd2);
        xlate("R2 literal", 48'h0000_3ABC, 1'b0);
        chk("R2 literal pa", 64'(rsp_pa), 64'h0010_3ABC);
        xlate("R10 literal table miss", 48'h0000_5000, 1'b0);
        chk("R10 literal fault", 64'({rsp_fault, rsp_size, rsp_pa}), {8'h0, 1'b1, 2'b0, 52'h0});

        // R4: bit 7 ignored without the large-page enable
        pse_on = 1'b0;
        for (int d = 1; d < 3; d++)
            for (int j = 0; j < 6; j++)
                xlate("R4 pse off sweep", (48'(d) << 22) | (48'(j) << 12) | 48'h0777, 1'b0);
        xlate("R4 literal", 48'h0080_2010, 1'b0);
        chk("R4 literal pa", 64'(rsp_pa), 64'h0033_5010);
        chk("R4 literal size", 64'(rsp_size), 64'd0);

        // R9: root only resolves through the mask
        pse_on = 1'b1;
        root_ptr = 64'h0010_1000;
        a20_mask = ~(52'h1 << 20);
        for (int d = 0; d < 3; d++)
            for (int j = 0; j < 4; j++)
                xlate("R9 masked root sweep", (48'(d) << 22) | (48'(j) << 12) | 48'h0123, 1'b0);
        xlate("R9 literal", 48'h0000_1456, 1'b0);
        chk("R9 literal pa", 64'(rsp_pa), 64'h0010_1456);
        a20_mask = '1;

        // R5 R6 R8 R11: extended three-level
        pae_on = 1'b1; long_on = 1'b0;
        root_ptr = 64'hABCD_0000_0000_303F;
        for (int p = 0; p < 4; p++)
            for (int d = 0; d < 4; d++)
                for (int j = 0; j < 10; j++)
                    xlate("R5 R6 R8 extended sweep",
                          (48'(p) << 30) | (48'(d) << 21) | (48'(j) << 12) | 48'((p*5 + d*3 + j*97) & 12'hfff), 1'b0);
        xlate("R6 literal 2MB", 48'h0020_0567, 1'b0);
        chk("R6 literal pa", 64'(rsp_pa), 64'h12_3400_0567);
        chk("R6 literal size", 64'(rsp_size), 64'd1);
        xlate("R8 literal", 48'h8000_2abc, 1'b0);
        chk("R8 literal pa", 64'(rsp_pa), 64'h1_2300_2abc);

        // R7 R8: four-level
        long_on = 1'b1;
        root_ptr = 64'hFFF0_0000_0000_8ABC;
        for (int pm = 0; pm < 3; pm++)
            for (int pd = 0; pd < 3; pd++)
                for (int di = 0; di < 3; di++)
                    for (int tj = 0; tj < 4; tj++)
                        xlate("R7 R8 four-level sweep",
                              (48'(pm) << 39) | (48'(pd) << 30) | (48'(di) << 21) | (48'(tj) << 12) | 48'(pm*7 + tj*211), 1'b0);
        xlate("R7 literal 1GB", 48'h0000_4123_4567, 1'b0);
        chk("R7 literal pa", 64'(rsp_pa), 64'h7_C123_4567);
        chk("R7 literal size", 64'(rsp_size), 64'd3);
        xlate("R11 literal beats", 48'h0000_0000_1000, 1'b0);
        chk("R11 literal read count", 64'(got_q.size()), 64'd8);

        // R12: request during a walk is ignored
        va = 48'h0000_0000_1000;
        xlate("R12 poke while busy", va, 1'b1);
        dones = 0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            if (done || mem_rd || busy) dones++;
        end
        chk("R12 no second response", 64'(dones), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule